// File: doc/BRIEF.md
# Binary Tree Up/Down Route Sequencer

This block decides how a packet crosses a binary tree network from a source leaf to a destination leaf, and then plays that route out one hop per clock cycle. Leaves carry an address of `LEVELS` bits, which is the left/right path from the root down to that leaf. The block XORs the two addresses. The highest set bit of the result fixes how many levels the packet climbs to reach the nearest common ancestor. The packet then descends the same number of levels, steered by the low bits of the destination address.

A request is loaded with a one-cycle `start_i` pulse while the unit is idle. The sequencer then drives one port choice per cycle: first the upward hops, then the downward hops, where each destination bit picks the left or the right child. After the last downward hop it raises `done_o` for one cycle. If source and destination are the same leaf, the unit emits no hops, reports local delivery and finishes at once. The climb height can be computed by either of two leading-one detectors, chosen by a parameter.

Top module: `tree_route_unit`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `hop_valid_o` and `done_o` are 0.
- R2: A `start_i` seen while `busy_o` is 0 loads the request. From the next cycle, `climb_o` equals one plus the bit position of the highest 1 in `src_i ^ dst_i`, and 0 when they are equal.
- R3: Starting in the cycle after the load, the unit drives `climb_o` consecutive cycles with `hop_valid_o`=1 and `hop_port_o`=2'b01 (climb toward the root).
- R4: Straight after the climb, it drives `climb_o` further hop cycles. The k-th of these (k counted from 0) uses destination bit `climb_o-1-k`: a 0 gives `hop_port_o`=2'b10 (left child) and a 1 gives 2'b11 (right child). No climb hop follows a descend hop.
- R5: `done_o` is high for exactly one cycle, in the cycle after the last descend hop. `busy_o` is 0 in the cycle that follows.
- R6: When `src_i == dst_i`, no hop is emitted. `done_o` is high in the first cycle after the load, with `local_o`=1 and `climb_o`=0. `local_o` is 0 for any other request.
- R7: A `start_i` pulse while `busy_o` is 1 is ignored: the hop sequence, `climb_o` and `local_o` of the running request are unchanged.
- R8: `hop_port_o` is 2'b00 in every cycle where `hop_valid_o` is 0.
- R9: A new request may be loaded in the first cycle in which `busy_o` has returned to 0, and it is routed as fully as the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load request (taken only when idle) |
| src_i | input | LEVELS | Source leaf address |
| dst_i | input | LEVELS | Destination leaf address |
| busy_o | output | 1 | Request in progress |
| hop_valid_o | output | 1 | A hop choice is being driven |
| hop_port_o | output | 2 | 01 up, 10 down-left, 11 down-right, 00 none |
| climb_o | output | $clog2(LEVELS+1) | Levels climbed by the loaded request |
| local_o | output | 1 | Loaded request needs no hops |
| done_o | output | 1 | One-cycle pulse after the final hop |

## Verification
A wrong climb height shows up in the first cycle after the load, in `climb_o`. It also shows as a climb run that is too long or too short, so the first descend hop appears in the wrong cycle. A descend index that is off by one, or that moves in the wrong direction, makes the first mismatching port visible within one hop of the descent. A state machine that fails to leave or return to idle shows up as a missing or stretched `done_o` pulse, or as `busy_o` still high in the cycle after it. A request that is not held correctly while busy corrupts the remaining hops of the running route. The scoreboard compares every hop, every done pulse and every idle cycle against a route computed independently. All leaf pairs are covered for the default size.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;

   typedef enum logic [1:0] {
      PORT_NONE  = 2'b00,
      PORT_UP    = 2'b01,
      PORT_LEFT  = 2'b10,
      PORT_RIGHT = 2'b11
   } hop_port_e;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'b00,
      ST_CLIMB   = 2'b01,
      ST_DESCEND = 2'b10,
      ST_FINISH  = 2'b11
   } seq_state_e;

endpackage

// File: rtl/tree_route_height.sv
module tree_route_height #(
   parameter int LEVELS = 4,
   parameter int CW     = 3,
   parameter bit THERMO = 1'b1
) (
   input  logic [LEVELS-1:0] diff_i,
   output logic [CW-1:0]     height_o,
   output logic              same_o
);

   assign same_o = (diff_i == '0);

   generate
      if (THERMO) begin : g_thermo
         logic [LEVELS-1:0] suffix_any;
         for (genvar j = 0; j < LEVELS; j++) begin : g_suf
            assign suffix_any[j] = |diff_i[LEVELS-1:j];
         end
         assign height_o = CW'($countones(suffix_any));
      end else begin : g_scan
         always_comb begin
            height_o = '0;
            for (int j = 0; j < LEVELS; j++) begin
               if (diff_i[j]) height_o = CW'(j + 1);
            end
         end
      end
   endgenerate

   // R2: the bit just below the height is set and nothing above it is
   always_comb begin
      if (!same_o) begin
         a_r2_height_is_msb: assert (diff_i[height_o - 1'b1] == 1'b1 &&
                                     (diff_i >> height_o) == '0);
      end else begin
         a_r2_height_zero: assert (height_o == '0);
      end
   end

endmodule

// File: rtl/tree_route_seq.sv
module tree_route_seq
   import tree_route_pkg::*;
#(
   parameter int LEVELS = 4,
   parameter int CW     = 3,
   parameter int IW     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LEVELS-1:0] dst_i,
   input  logic [CW-1:0]     height_i,
   input  logic              same_i,
   output logic              busy_o,
   output logic              hop_valid_o,
   output logic [1:0]        hop_port_o,
   output logic [CW-1:0]     climb_o,
   output logic              local_o,
   output logic              done_o
);

   seq_state_e        state_q;
   logic [LEVELS-1:0] dst_q;
   logic [CW-1:0]     up_left_q;
   logic [IW-1:0]     down_idx_q;
   logic [CW-1:0]     climb_q;
   logic              local_q;
   logic              accept;

   assign accept = start_i && (state_q == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         dst_q      <= '0;
         up_left_q  <= '0;
         down_idx_q <= '0;
         climb_q    <= '0;
         local_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  dst_q     <= dst_i;
                  climb_q   <= height_i;
                  local_q   <= same_i;
                  up_left_q <= height_i;
                  state_q   <= same_i ? ST_FINISH : ST_CLIMB;
               end
            end
            ST_CLIMB: begin
               if (up_left_q == CW'(1)) begin
                  down_idx_q <= IW'(climb_q - CW'(1));
                  state_q    <= ST_DESCEND;
               end else begin
                  up_left_q <= up_left_q - CW'(1);
               end
            end
            ST_DESCEND: begin
               if (down_idx_q == '0) state_q <= ST_FINISH;
               else                  down_idx_q <= down_idx_q - IW'(1);
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      hop_port_o = PORT_NONE;
      case (state_q)
         ST_CLIMB:   hop_port_o = PORT_UP;
         ST_DESCEND: hop_port_o = dst_q[down_idx_q] ? PORT_RIGHT : PORT_LEFT;
         default:    hop_port_o = PORT_NONE;
      endcase
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign hop_valid_o = (state_q == ST_CLIMB) || (state_q == ST_DESCEND);
   assign done_o      = (state_q == ST_FINISH);
   assign climb_o     = climb_q;
   assign local_o     = local_q;

   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

   a_r4_no_climb_after_descend: assert property (@(posedge clk) disable iff (!rst_n)
      (hop_valid_o && hop_port_o[1]) |=> !(hop_valid_o && hop_port_o == PORT_UP));

   a_r6_local_no_climb: assert property (@(posedge clk) disable iff (!rst_n)
      local_o |-> (climb_o == '0));

   a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> ($stable(climb_o) && $stable(local_o)));

   a_r2_climb_range: assert property (@(posedge clk) disable iff (!rst_n)
      climb_o <= CW'(LEVELS));

endmodule

// File: rtl/tree_route_unit.sv
module tree_route_unit #(
   parameter int LEVELS = 4,
   parameter bit THERMO = 1'b1,
   localparam int CW = $clog2(LEVELS + 1),
   localparam int IW = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LEVELS-1:0] src_i,
   input  logic [LEVELS-1:0] dst_i,
   output logic              busy_o,
   output logic              hop_valid_o,
   output logic [1:0]        hop_port_o,
   output logic [CW-1:0]     climb_o,
   output logic              local_o,
   output logic              done_o
);

   generate
      if (LEVELS < 1 || LEVELS > 16) begin : g_bad_levels
         $error("tree_route_unit: LEVELS must lie in 1..16");
      end
   endgenerate

   logic [LEVELS-1:0] rel_addr;
   logic [CW-1:0]     height;
   logic              same;

   assign rel_addr = src_i ^ dst_i;

   tree_route_height #(
      .LEVELS (LEVELS),
      .CW     (CW),
      .THERMO (THERMO)
   ) u_height (
      .diff_i   (rel_addr),
      .height_o (height),
      .same_o   (same)
   );

   tree_route_seq #(
      .LEVELS (LEVELS),
      .CW     (CW),
      .IW     (IW)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .dst_i       (dst_i),
      .height_i    (height),
      .same_i      (same),
      .busy_o      (busy_o),
      .hop_valid_o (hop_valid_o),
      .hop_port_o  (hop_port_o),
      .climb_o     (climb_o),
      .local_o     (local_o),
      .done_o      (done_o)
   );

   a_r8_idle_port_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !hop_valid_o |-> (hop_port_o == 2'b00));

endmodule

// File: tb/tree_route_unit_tb.sv
`timescale 1ns/1ps
module tree_route_unit_tb;
   localparam int LV = 4;
   localparam int CW = $clog2(LV + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [LV-1:0] src = '0;
   logic [LV-1:0] dst = '0;
   logic          busy_o, hop_valid_o, local_o, done_o;
   logic [1:0]    hop_port_o;
   logic [CW-1:0] climb_o;

   int n_chk = 0;
   int n_bad = 0;
   int exp_q[$];
   bit chk_idle_next = 1'b0;

   always #2.5 clk = ~clk;

   tree_route_unit #(.LEVELS(LV)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .src_i(src), .dst_i(dst),
      .busy_o(busy_o), .hop_valid_o(hop_valid_o), .hop_port_o(hop_port_o),
      .climb_o(climb_o), .local_o(local_o), .done_o(done_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Monitor: pops scoreboard items as the design produces them
   always @(negedge clk) begin
      int e;
      if (rst_n) begin
         if (chk_idle_next) begin
            check(!busy_o && !done_o, "R5 idle after done pulse", {busy_o, done_o}, 0);
            chk_idle_next = 1'b0;
         end
         if (hop_valid_o) begin
            if (exp_q.size() == 0) check(1'b0, "R3 unexpected hop", hop_port_o, -1);
            else begin
               e = exp_q.pop_front();
               check(hop_port_o == e, (e == 1) ? "R3 climb hop" : "R4 descend hop",
                     hop_port_o, e);
            end
         end else begin
            check(hop_port_o == 2'b00, "R8 idle port", hop_port_o, 0);
         end
         if (done_o) begin
            if (exp_q.size() == 0) check(1'b0, "R5 unexpected done", 1, 0);
            else begin
               e = exp_q.pop_front();
               check(e >= 100, "R5 done before last hop", 100, e);
               if (e >= 100) begin
                  check(climb_o == ((e - 100) >> 1), "R2 climb height", climb_o, (e - 100) >> 1);
                  check(local_o == ((e - 100) & 1), "R6 local flag", local_o, (e - 100) & 1);
               end
            end
            chk_idle_next = 1'b1;
         end
      end
   end

   task automatic route(input logic [LV-1:0] s, input logic [LV-1:0] d);
      int h;
      logic [LV-1:0] r;
      @(negedge clk);
      while (busy_o) @(negedge clk);
      r = s ^ d;
      h = 0;
      for (int j = 0; j < LV; j++) if (r[j]) h = j + 1;
      for (int k = 0; k < h; k++) exp_q.push_back(1);
      for (int k = h - 1; k >= 0; k--) exp_q.push_back(d[k] ? 3 : 2);
      exp_q.push_back(100 + 2 * h + ((h == 0) ? 1 : 0));
      src = s; dst = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (h == 0) check(done_o && local_o && !hop_valid_o, "R6 immediate local done",
                        {done_o, local_o, hop_valid_o}, 6);
   endtask

   task automatic poke(input logic [LV-1:0] s, input logic [LV-1:0] d, input int n);
      for (int c = 0; c < n; c++) begin
         src = s; dst = d; start = 1'b1;
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!busy_o && !hop_valid_o && !done_o, "R1 outputs in reset",
            {busy_o, hop_valid_o, done_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !hop_valid_o && !done_o, "R1 outputs after reset",
            {busy_o, hop_valid_o, done_o}, 0);
      // Specific corners: full climb, single level, local
      route(4'd0, 4'd15);
      route(4'd6, 4'd7);
      route(4'd9, 4'd9);
      route(4'd8, 4'd3);
      // R7: start pulses while busy must not disturb the running route
      route(4'd0, 4'd10);
      poke(4'd5, 4'd5, 3);
      poke(4'd1, 4'd14, 2);
      // R9: back-to-back requests across every leaf pair
      for (int a = 0; a < (1 << LV); a++)
         for (int b = 0; b < (1 << LV); b++)
            route(LV'(a), LV'(b));
      @(negedge clk);
      while (busy_o) @(negedge clk);
      repeat (2) @(negedge clk);
      check(exp_q.size() == 0, "R9 all routes delivered", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule